// File: doc/BRIEF.md
# Lock-Aware Two-Way Cache Tag Controller

This block keeps the tag, valid, owner and lock state of a small two-way set-associative data cache and decides, for every request, whether it hits, which way it uses, and what a miss may displace. Each request carries an address, a read/write flag, an owner ID and a lock opcode (none, lock, unlock). Software protects sensitive lines by accessing them with the lock opcode. The replacement logic then keeps those lines resident against other owners, and against unlocked fills from the same owner.

A hit is answered on the next cycle. If the hit carries a lock or unlock opcode, the line's lock bit and owner stamp change at the same clock edge. A miss waits a fixed refill penalty and then requests the line over a request/acknowledge port. If both ways of the set are protected against the requester, the access is served uncached: the same port is used, a bypass flag is returned and no line is written. Data storage is outside the block.

Top module: `llc_top`

## Requirements
- R1: After reset every line is invalid and unlocked, and the LRU state is cleared. `req_ready` is 1, and `resp_valid` and `fill_req` are 0. The first access to any address misses.
- R2: A request accepted while `req_ready` is high that hits is answered in the following cycle with `resp_valid`=1, `resp_hit`=1, `resp_bypass`=0 and `resp_way` set to the way holding the line.
- R3: A request that misses drops `req_ready` for the rest of the access. `fill_req` rises exactly REFILL_CYCLES cycles after the accepting edge. `fill_addr` holds the line address (request address with the offset bits zeroed) until acknowledged. The response (`resp_hit`=0) comes the cycle after the edge on which `fill_ack` is seen with `fill_req` high.
- R4: On a miss, an invalid way is chosen before any valid way, and way 0 is chosen before way 1. If both ways are valid and replaceable, the least recently used way is chosen.
- R5: Each set has one LRU bit. A hit or a fill makes the way it used the most recently used way.
- R6: A locked line may be replaced by a request from its own owner only when that request carries the lock opcode. An own-owner request with opcode none or unlock never evicts it.
- R7: A request from one owner never evicts a line that is locked and stamped with a different owner.
- R8: When no way of the set may be replaced, the response has `resp_bypass`=1, `resp_hit`=0 and `resp_way`=0. No line is written, so a repeat of the access misses again and the resident lines still hit.
- R9: A lock hit (opcode 1) sets the line's lock bit, and an unlock hit (opcode 2) clears it. Either one stamps the line with the requester's owner ID at the hit edge. Opcodes 0 and 3 leave lock and owner unchanged.
- R10: A miss that allocates writes the line with the requester's owner ID and with its lock bit set exactly when the opcode is lock. This holds for reads and writes alike (`req_write` does not affect lookup or replacement).
- R11: The address splits into offset (low log2(LINE_BYTES) bits), set index (next log2(SETS) bits) and tag (the rest). Accesses differing only in offset hit the same line, and sets are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken on a clock edge while req_ready is high |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 for store, 0 for load |
| req_owner | input | OWN_W | Owner ID of the requester |
| req_lock_op | input | 2 | 0 none, 1 lock, 2 unlock, 3 treated as none |
| fill_req | output | 1 | Refill or uncached fetch requested |
| fill_addr | output | ADDR_W | Line address being fetched |
| fill_ack | input | 1 | Refill complete |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Access hit |
| resp_bypass | output | 1 | Access was served uncached |
| resp_way | output | 1 | Way hit or allocated |

## Verification
A hit's response is due one cycle after the accepting edge. The bench drives inputs on falling edges and checks `resp_valid` at the very next falling edge. For a miss, the bench counts falling edges from the accepting edge until `fill_req` appears and expects exactly REFILL_CYCLES. It then returns the acknowledge at that falling edge and expects the response one cycle later. A scoreboard queue holds the expected hit, bypass and way values for each access. The monitor pops one entry for every response strobe, so a response that is early, late or missing shows up as a mismatch or as a leftover entry. The replacement cases run in one set with LRU state tracked by hand, so each chosen way tells a correct guard apart from a broken one.

// File: rtl/llc_pkg.sv
// Shared types for the lock-aware cache tag controller.
// Assumes a two-way organisation (one LRU bit per set).
package llc_pkg;
    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        LK_NONE = 2'd0,
        LK_SET  = 2'd1,
        LK_CLR  = 2'd2,
        LK_RSVD = 2'd3
    } lock_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FILL = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/llc_tag_store.sv
// Per-way tag, valid, owner and lock arrays plus a per-set LRU bit.
// Read is combinational at rd_idx. Writes happen at the clock edge: a full
// line write (fill) takes priority over a metadata write (lock/unlock hit).
// Assumes writes always target the set at rd_idx.
module llc_tag_store
    import llc_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int TAG_W = 7,
    parameter int OWN_W = 4,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0]             rd_lock,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0][OWN_W-1:0]  rd_owner,
    output logic                        rd_lru,
    input  logic                        line_we,
    input  logic                        line_way,
    input  logic [TAG_W-1:0]            line_tag,
    input  logic [OWN_W-1:0]            line_owner,
    input  logic                        line_lock,
    input  logic                        meta_we,
    input  logic                        meta_way,
    input  logic [OWN_W-1:0]            meta_owner,
    input  logic                        meta_lock,
    input  logic                        lru_we,
    input  logic                        lru_used_way
);
    logic [SETS-1:0] lru_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]             valid_q;
        logic [SETS-1:0]             lock_q;
        logic [SETS-1:0][TAG_W-1:0]  tag_q;
        logic [SETS-1:0][OWN_W-1:0]  owner_q;
        logic                        line_hit_w;
        logic                        meta_hit_w;

        assign line_hit_w = line_we && (line_way == w[0]);
        assign meta_hit_w = meta_we && (meta_way == w[0]);

        // Hold and update the state of this way.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= '0;
                lock_q  <= '0;
                tag_q   <= '0;
                owner_q <= '0;
            end else if (line_hit_w) begin
                valid_q[rd_idx] <= 1'b1;
                tag_q[rd_idx]   <= line_tag;
                owner_q[rd_idx] <= line_owner;
                lock_q[rd_idx]  <= line_lock;
            end else if (meta_hit_w) begin
                owner_q[rd_idx] <= meta_owner;
                lock_q[rd_idx]  <= meta_lock;
            end
        end

        assign rd_valid[w] = valid_q[rd_idx];
        assign rd_lock[w]  = lock_q[rd_idx];
        assign rd_tag[w]   = tag_q[rd_idx];
        assign rd_owner[w] = owner_q[rd_idx];
    end

    // LRU bit names the least recently used way of each set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lru_q <= '0;
        else if (lru_we)
            lru_q[rd_idx] <= ~lru_used_way;
    end

    assign rd_lru = lru_q[rd_idx];
endmodule

// File: rtl/llc_victim_sel.sv
// Combinational lookup and lock-aware victim choice for one set.
// A way is replaceable when invalid, unlocked, or locked by the requester
// itself with a lock opcode. Invalid ways win, lowest index first, then LRU.
// Assumes two ways.
module llc_victim_sel
    import llc_pkg::*;
#(
    parameter int TAG_W = 7,
    parameter int OWN_W = 4
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0]             way_lock,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [WAYS-1:0][OWN_W-1:0]  way_owner,
    input  logic                        lru,
    input  logic [TAG_W-1:0]            req_tag,
    input  logic [OWN_W-1:0]            req_owner,
    input  lock_op_e                    req_op,
    output logic                        hit_any,
    output logic                        hit_way,
    output logic                        victim_way,
    output logic                        bypass
);
    logic [WAYS-1:0] hit_vec;
    logic [WAYS-1:0] repl_ok;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
        assign repl_ok[w] = !way_valid[w] || !way_lock[w] ||
                            ((way_owner[w] == req_owner) && (req_op == LK_SET));
    end

    assign hit_any = |hit_vec;
    assign hit_way = hit_vec[1];
    assign bypass  = ~|repl_ok;

    // Pick the way to fill on a miss.
    always_comb begin
        if (!way_valid[0])
            victim_way = 1'b0;
        else if (!way_valid[1])
            victim_way = 1'b1;
        else if (&repl_ok)
            victim_way = lru;
        else
            victim_way = !repl_ok[0];
    end
endmodule

// File: rtl/llc_top.sv
// Lock-aware two-way cache tag controller. Hits answer in one cycle and
// apply lock/unlock at the hit edge; misses wait REFILL_CYCLES, then fetch
// through fill_req/fill_ack and either allocate or bypass.
// Assumes the fill agent keeps fill_ack low unless fill_req is high.
module llc_top
    import llc_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int LINE_BYTES    = 64,
    parameter int SETS          = 8,
    parameter int OWN_W         = 4,
    parameter int REFILL_CYCLES = 10,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
    localparam int CNT_W  = $clog2(REFILL_CYCLES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [OWN_W-1:0]  req_owner,
    input  logic [1:0]        req_lock_op,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_ack,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_bypass,
    output logic              resp_way
);
    ctl_state_e state_q;
    logic [CNT_W-1:0] cnt_q;

    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    lock_op_e         req_op;

    logic [TAG_W-1:0] lat_tag;
    logic [IDX_W-1:0] lat_idx;
    logic [OWN_W-1:0] lat_owner;
    lock_op_e         lat_op;
    logic             lat_way;
    logic             lat_bypass;

    logic [IDX_W-1:0]            cur_idx;
    logic [WAYS-1:0]             rd_valid;
    logic [WAYS-1:0]             rd_lock;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0][OWN_W-1:0]  rd_owner;
    logic                        rd_lru;

    logic hit_any, hit_way, victim_way, bypass;
    logic hit_take, fill_take, line_we, meta_we, lru_we, lru_used_way;
    logic line_lock;
    logic unused_write;

    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx = req_addr[OFF_W +: IDX_W];
    assign req_op  = lock_op_e'(req_lock_op);
    assign unused_write = req_write;

    // The set being looked at: live request when idle, latched miss otherwise.
    assign cur_idx = (state_q == ST_IDLE) ? req_idx : lat_idx;

    llc_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .OWN_W(OWN_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_idx       (cur_idx),
        .rd_valid     (rd_valid),
        .rd_lock      (rd_lock),
        .rd_tag       (rd_tag),
        .rd_owner     (rd_owner),
        .rd_lru       (rd_lru),
        .line_we      (line_we),
        .line_way     (lat_way),
        .line_tag     (lat_tag),
        .line_owner   (lat_owner),
        .line_lock    (line_lock),
        .meta_we      (meta_we),
        .meta_way     (hit_way),
        .meta_owner   (req_owner),
        .meta_lock    (req_op == LK_SET),
        .lru_we       (lru_we),
        .lru_used_way (lru_used_way)
    );

    llc_victim_sel #(.TAG_W(TAG_W), .OWN_W(OWN_W)) u_sel (
        .way_valid  (rd_valid),
        .way_lock   (rd_lock),
        .way_tag    (rd_tag),
        .way_owner  (rd_owner),
        .lru        (rd_lru),
        .req_tag    (req_tag),
        .req_owner  (req_owner),
        .req_op     (req_op),
        .hit_any    (hit_any),
        .hit_way    (hit_way),
        .victim_way (victim_way),
        .bypass     (bypass)
    );

    // Write strobes into the tag store.
    always_comb begin
        hit_take     = (state_q == ST_IDLE) && req_valid && hit_any;
        fill_take    = (state_q == ST_FILL) && fill_ack;
        line_we      = fill_take && !lat_bypass;
        meta_we      = hit_take && ((req_op == LK_SET) || (req_op == LK_CLR));
        lru_we       = hit_take || line_we;
        lru_used_way = hit_take ? hit_way : lat_way;
        line_lock    = (lat_op == LK_SET);
    end

    assign req_ready = (state_q == ST_IDLE);
    assign fill_req  = (state_q == ST_FILL);
    assign fill_addr = {lat_tag, lat_idx, {OFF_W{1'b0}}};

    // Sequence lookup, refill wait and fill, and register the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            lat_tag     <= '0;
            lat_idx     <= '0;
            lat_owner   <= '0;
            lat_op      <= LK_NONE;
            lat_way     <= 1'b0;
            lat_bypass  <= 1'b0;
            resp_valid  <= 1'b0;
            resp_hit    <= 1'b0;
            resp_bypass <= 1'b0;
            resp_way    <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid && hit_any) begin
                        resp_valid  <= 1'b1;
                        resp_hit    <= 1'b1;
                        resp_bypass <= 1'b0;
                        resp_way    <= hit_way;
                    end else if (req_valid) begin
                        lat_tag    <= req_tag;
                        lat_idx    <= req_idx;
                        lat_owner  <= req_owner;
                        lat_op     <= req_op;
                        lat_way    <= bypass ? 1'b0 : victim_way;
                        lat_bypass <= bypass;
                        cnt_q      <= '0;
                        state_q    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == CNT_W'(REFILL_CYCLES - 1))
                        state_q <= ST_FILL;
                    else
                        cnt_q <= cnt_q + 1'b1;
                end
                ST_FILL: begin
                    if (fill_ack) begin
                        resp_valid  <= 1'b1;
                        resp_hit    <= 1'b0;
                        resp_bypass <= lat_bypass;
                        resp_way    <= lat_way;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/llc_checker.sv
// Protocol and replacement-guard properties for llc_top, attached by bind.
// Assumes two ways; rd_* are the tag store outputs for the set being filled.
module llc_checker #(
    parameter int ADDR_W = 16,
    parameter int OWN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              fill_req,
    input logic              fill_ack,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              resp_bypass,
    input logic              hit_take,
    input logic              line_we,
    input logic              line_way,
    input logic              line_lock,
    input logic [OWN_W-1:0]  line_owner,
    input logic [1:0]        rd_valid,
    input logic [1:0]        rd_lock,
    input logic [1:0][OWN_W-1:0] rd_owner
);
    a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        hit_take |=> (resp_valid && resp_hit && !resp_bypass));

    a_r3_busy_while_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !req_ready);

    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_ack) |=> (fill_req && $stable(fill_addr)));

    a_r3_fill_then_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_ack) |=> (resp_valid && !resp_hit));

    a_r7_foreign_lock_kept: assert property (@(posedge clk) disable iff (!rst_n)
        line_we |-> !(rd_valid[line_way] && rd_lock[line_way] &&
                      (rd_owner[line_way] != line_owner)));

    a_r6_own_lock_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (line_we && rd_valid[line_way] && rd_lock[line_way]) |-> line_lock);

    a_r8_bypass_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_bypass) |-> !resp_hit);
endmodule

bind llc_top llc_checker #(.ADDR_W(ADDR_W), .OWN_W(OWN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .fill_req    (fill_req),
    .fill_ack    (fill_ack),
    .fill_addr   (fill_addr),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .resp_bypass (resp_bypass),
    .hit_take    (hit_take),
    .line_we     (line_we),
    .line_way    (lat_way),
    .line_lock   (line_lock),
    .line_owner  (lat_owner),
    .rd_valid    (rd_valid),
    .rd_lock     (rd_lock),
    .rd_owner    (rd_owner)
);

// File: tb/sim_llc_top.sv
// Scoreboard bench: the access task queues expected responses, a monitor
// pops and compares them on each response strobe.
module sim_llc_top;
    localparam int REF = 10;

    typedef struct packed {
        logic hit;
        logic byp;
        logic way;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [3:0]  req_owner = '0;
    logic [1:0]  req_lock_op = '0;
    logic        fill_req;
    logic [15:0] fill_addr;
    logic        fill_ack = 1'b0;
    logic        resp_valid, resp_hit, resp_bypass, resp_way;

    int    n_tests = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    exp_t  exp_q[$];
    string lbl_q[$];

    always #5 clk = ~clk;

    llc_top #(.REFILL_CYCLES(REF)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_owner(req_owner),
        .req_lock_op(req_lock_op), .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_ack(fill_ack), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_bypass(resp_bypass), .resp_way(resp_way)
    );

    task automatic chk(input bit ok, input string lbl, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", lbl, act, expv);
        end
    endtask

    // Fill agent: acknowledge on the falling edge after a request appears.
    always @(negedge clk) fill_ack <= fill_req;

    // Monitor: compare each response with the oldest expected entry.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected response", 1, 0);
            end else begin
                exp_t  e;
                string l;
                e = exp_q.pop_front();
                l = lbl_q.pop_front();
                chk(resp_hit == e.hit, {l, " hit"}, int'(resp_hit), int'(e.hit));
                chk(resp_bypass == e.byp, {l, " bypass"}, int'(resp_bypass), int'(e.byp));
                chk(resp_way == e.way, {l, " way"}, int'(resp_way), int'(e.way));
            end
        end
    end

    task automatic access(input logic [6:0] tg, input logic [2:0] ix,
                          input logic [5:0] off, input logic wr,
                          input logic [3:0] own, input logic [1:0] op,
                          input logic eh, input logic eb, input logic ew,
                          input string lbl);
        int k;
        exp_q.push_back('{hit: eh, byp: eb, way: ew});
        lbl_q.push_back(lbl);
        @(negedge clk);
        req_addr    = {tg, ix, off};
        req_write   = wr;
        req_owner   = own;
        req_lock_op = op;
        req_valid   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (eh) begin
            chk(resp_valid == 1'b1, {lbl, " R2 response one cycle after accept"},
                int'(resp_valid), 1);
        end else begin
            chk(req_ready == 1'b0, {lbl, " R3 busy during miss"}, int'(req_ready), 0);
            k = 0;
            while (!fill_req && k < 50) begin
                @(negedge clk);
                k++;
            end
            chk(k == REF, {lbl, " R3 refill penalty"}, k, REF);
            chk(fill_addr == {tg, ix, 6'd0}, {lbl, " R3 fill address"},
                int'(fill_addr), int'({tg, ix, 6'd0}));
            @(negedge clk);
            chk(resp_valid == 1'b1, {lbl, " R3 response after ack"}, int'(resp_valid), 1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(resp_valid == 1'b0, "R1 no response after reset", int'(resp_valid), 0);
        chk(fill_req == 1'b0, "R1 no fill after reset", int'(fill_req), 0);

        // Set 1, owners A=1 and B=2. Op: 0 none, 1 lock, 2 unlock.
        access(7'd5, 3'd1, 6'd0,  0, 4'd1, 2'd0, 0, 0, 0, "R1 R4 cold miss way0");
        access(7'd5, 3'd1, 6'h3F, 0, 4'd1, 2'd0, 1, 0, 0, "R11 R2 offset hit");
        access(7'd6, 3'd1, 6'd0,  0, 4'd1, 2'd0, 0, 0, 1, "R4 invalid way1");
        access(7'd5, 3'd1, 6'd4,  0, 4'd1, 2'd0, 1, 0, 0, "R5 touch way0");
        access(7'd7, 3'd1, 6'd0,  0, 4'd1, 2'd0, 0, 0, 1, "R5 R4 LRU victim");
        access(7'd5, 3'd1, 6'd0,  0, 4'd1, 2'd1, 1, 0, 0, "R9 lock hit");
        access(7'd7, 3'd1, 6'd0,  0, 4'd1, 2'd0, 1, 0, 1, "R5 hit way1");
        access(7'd8, 3'd1, 6'd0,  0, 4'd1, 2'd0, 0, 0, 1, "R6 own lock kept");
        access(7'd9, 3'd1, 6'd0,  0, 4'd1, 2'd1, 0, 0, 0, "R6 own lock replaced by lock");
        access(7'd10,3'd1, 6'd0,  0, 4'd2, 2'd1, 0, 0, 1, "R7 foreign lock kept");
        access(7'd11,3'd1, 6'd0,  0, 4'd1, 2'd0, 0, 1, 0, "R8 bypass");
        access(7'd11,3'd1, 6'd0,  0, 4'd1, 2'd0, 0, 1, 0, "R8 bypass not installed");
        access(7'd9, 3'd1, 6'd0,  0, 4'd1, 2'd0, 1, 0, 0, "R8 way0 line intact");
        access(7'd10,3'd1, 6'd0,  0, 4'd2, 2'd0, 1, 0, 1, "R10 R8 way1 line intact");
        access(7'd10,3'd1, 6'd0,  0, 4'd2, 2'd2, 1, 0, 1, "R9 unlock hit");
        access(7'd11,3'd1, 6'd0,  0, 4'd1, 2'd0, 0, 0, 1, "R9 unlocked line replaced");
        access(7'd9, 3'd1, 6'd0,  0, 4'd2, 2'd1, 1, 0, 0, "R9 lock hit stamps owner");
        access(7'd11,3'd1, 6'd0,  0, 4'd1, 2'd0, 1, 0, 1, "R5 make way0 LRU");
        access(7'd13,3'd1, 6'd0,  0, 4'd1, 2'd1, 0, 0, 1, "R9 stamped owner guards");

        // Set 2: store-and-lock, store without lock.
        access(7'd14,3'd2, 6'd0,  1, 4'd2, 2'd1, 0, 0, 0, "R10 store-lock alloc");
        access(7'd15,3'd2, 6'd0,  1, 4'd2, 2'd0, 0, 0, 1, "R10 store alloc way1");
        access(7'd15,3'd2, 6'd8,  0, 4'd2, 2'd0, 1, 0, 1, "R5 touch way1");
        access(7'd16,3'd2, 6'd0,  0, 4'd2, 2'd0, 0, 0, 1, "R10 store-lock line kept");
        access(7'd13,3'd1, 6'd0,  0, 4'd1, 2'd0, 1, 0, 1, "R11 set1 unaffected");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
        finish_run();
    end
endmodule